// File: doc/BRIEF.md
# Terminal Character Acceptance Controller

This block stands between a host that emits 7-bit ASCII codes and a display memory that recirculates past a cursor slot. The host presents one code with a single-cycle strobe; the block holds it, raises a level busy flag and waits until the display logic reports that the cursor slot is passing. At that moment it decides what to do with the held code.

A printable code (bit 6 or bit 5 set) is written into the exposed slot, and the cursor is told to advance. A carriage return (exactly 0x0D) starts a blank-fill: blanks are written at each exposed cursor slot until the slot that opens a new line comes round. Any other code below 0x20 is dropped. When handling ends, a fixed-length acknowledge pulse goes back to the host side, and busy falls at the end of that pulse.

Top module: `char_accept_ctrl`

## Requirements
- R1: After reset, busy, ack_pulse, mem_wr, clr_req and cur_adv are all 0.
- R2: A host_strobe while busy is 0 captures host_data into wr_char, and busy reads 1 from the next cycle on.
- R3: A host_strobe while busy is 1 is ignored: wr_char keeps the held code and handling proceeds for that held code.
- R4: For a held code with bit 6 or bit 5 set, mem_wr and cur_adv are 1, with clr_req 0, for exactly the one cycle after the first cycle in which slot_exposed is 1; no write happens before that.
- R5: A held code in 0x00..0x1F other than 0x0D causes no mem_wr and no cur_adv, yet the acknowledge still starts in the cycle after the next slot_exposed.
- R6: Only the full 7-bit value 0x0D is a carriage return (0x2D, 0x4D are printable). For it, the first exposed slot always gets a blank write (mem_wr, clr_req and cur_adv together for one cycle); each later exposed slot with line_start 0 gets another blank write; the first later exposed slot with line_start 1 gets no write and starts the acknowledge.
- R7: ack_pulse is 1 for exactly ACK_CYCLES cycles, starting in the cycle after the handling slot; busy falls in the same cycle that ack_pulse falls.
- R8: While busy is 0, slot_exposed and line_start pulses cause no write, no clear, no advance and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_data | input | CODE_W | Code offered by the host |
| host_strobe | input | 1 | One-cycle write strobe from the host |
| slot_exposed | input | 1 | One-cycle flag: the cursor slot is passing now |
| line_start | input | 1 | With slot_exposed: the passing cursor slot is the first of a line |
| busy | output | 1 | Level flag: a code is held, host must wait |
| ack_pulse | output | 1 | Acknowledge pulse back to the host side |
| mem_wr | output | 1 | Write strobe to display memory |
| clr_req | output | 1 | With mem_wr: write a blank instead of wr_char |
| cur_adv | output | 1 | Cursor advance pulse |
| wr_char | output | CODE_W | Held code, the data for a printable write |

## Verification
The hardest case to reach is a carriage return spanning several cursor passes, where only the pass carrying line_start ends the fill and a line_start seen on the very first pass must still be ignored. The bench drives slot_exposed by hand, choosing per vector how many blank passes precede the line-start pass, including zero, and shows line_start on the first pass of one return. A strobe is also injected during the wait to show the held code survives.

// File: rtl/char_accept_pkg.sv
package char_accept_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_FILL,
      ST_ACK
   } acc_state_t;

   typedef enum logic [1:0] {
      CK_CTRL,
      CK_PRINT,
      CK_RETURN
   } code_kind_t;

   localparam logic [6:0] ASCII_RETURN = 7'h0D;

endpackage

// File: rtl/code_classifier.sv
module code_classifier
   import char_accept_pkg::*;
#(
   parameter int CODE_W = 7
) (
   input  logic [CODE_W-1:0] code,
   output code_kind_t        kind
);

   logic upper_zero;

   generate
      if (CODE_W < 7) begin : g_bad_width
         $error("code_classifier: CODE_W must be at least 7");
      end
      if (CODE_W > 7) begin : g_wide
         assign upper_zero = ~|code[CODE_W-1:7];
      end else begin : g_narrow
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      if (code[6] | code[5]) begin
         kind = CK_PRINT;
      end else if (upper_zero && (code[6:0] == ASCII_RETURN)) begin
         kind = CK_RETURN;
      end else begin
         kind = CK_CTRL;
      end
   end

endmodule

// File: rtl/ack_timer.sv
module ack_timer #(
   parameter int ACK_CYCLES = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active,
   output logic last
);

   generate
      if (ACK_CYCLES < 1) begin : g_bad_len
         $error("ack_timer: ACK_CYCLES must be at least 1");
      end
      if (ACK_CYCLES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) active <= 1'b0;
            else        active <= start;
         end
         assign last = active;
      end else begin : g_count
         localparam int CNT_W = $clog2(ACK_CYCLES);
         localparam logic [CNT_W-1:0] LOAD = CNT_W'(ACK_CYCLES - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               active <= 1'b0;
               cnt    <= '0;
            end else if (start) begin
               active <= 1'b1;
               cnt    <= LOAD;
            end else if (active) begin
               if (cnt == '0) active <= 1'b0;
               else           cnt    <= cnt - 1'b1;
            end
         end
         assign last = active && (cnt == '0);

         // R7
         ack_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (active && cnt != '0 && !start) |=> active);
      end
   endgenerate

endmodule

// File: rtl/char_accept_ctrl.sv
module char_accept_ctrl
   import char_accept_pkg::*;
#(
   parameter int CODE_W     = 7,
   parameter int ACK_CYCLES = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] host_data,
   input  logic              host_strobe,
   input  logic              slot_exposed,
   input  logic              line_start,
   output logic              busy,
   output logic              ack_pulse,
   output logic              mem_wr,
   output logic              clr_req,
   output logic              cur_adv,
   output logic [CODE_W-1:0] wr_char
);

   acc_state_t        state;
   code_kind_t        kind;
   logic [CODE_W-1:0] held;
   logic              wr_q, clr_q, adv_q;
   logic              tmr_start, tmr_active, tmr_last;

   code_classifier #(.CODE_W(CODE_W)) u_class (
      .code (held),
      .kind (kind)
   );

   always_comb begin
      tmr_start = 1'b0;
      if (slot_exposed) begin
         if (state == ST_WAIT && kind != CK_RETURN) tmr_start = 1'b1;
         if (state == ST_FILL && line_start)        tmr_start = 1'b1;
      end
   end

   ack_timer #(.ACK_CYCLES(ACK_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tmr_start),
      .active (tmr_active),
      .last   (tmr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         held  <= '0;
         wr_q  <= 1'b0;
         clr_q <= 1'b0;
         adv_q <= 1'b0;
      end else begin
         wr_q  <= 1'b0;
         clr_q <= 1'b0;
         adv_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (host_strobe) begin
                  held  <= host_data;
                  state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (slot_exposed) begin
                  unique case (kind)
                     CK_PRINT: begin
                        wr_q  <= 1'b1;
                        adv_q <= 1'b1;
                        state <= ST_ACK;
                     end
                     CK_RETURN: begin
                        wr_q  <= 1'b1;
                        clr_q <= 1'b1;
                        adv_q <= 1'b1;
                        state <= ST_FILL;
                     end
                     default: state <= ST_ACK;
                  endcase
               end
            end
            ST_FILL: begin
               if (slot_exposed) begin
                  if (line_start) begin
                     state <= ST_ACK;
                  end else begin
                     wr_q  <= 1'b1;
                     clr_q <= 1'b1;
                     adv_q <= 1'b1;
                  end
               end
            end
            ST_ACK: begin
               if (tmr_last) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign ack_pulse = tmr_active;
   assign mem_wr    = wr_q;
   assign clr_req   = clr_q;
   assign cur_adv   = adv_q;
   assign wr_char   = held;

   // R2
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(host_strobe));
   // R3
   held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_strobe) |=> $stable(wr_char));
   // R4
   wr_exposed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(slot_exposed));
   // R5
   ctrl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !clr_req) |-> (wr_char[6] | wr_char[5]));
   // R6
   clr_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |-> (mem_wr && cur_adv));
   // R7
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_pulse) |-> $fell(busy));
   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_wr && !ack_pulse));

endmodule

// File: tb/char_accept_ctrl_tb.sv
module char_accept_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ACK_N      = 7;
   localparam int NVEC       = 14;

   // vector: [14:8] code, [7:6] kind (0 ctrl,1 print,2 return), [3:0] extra blank passes
   localparam logic [14:0] VECS [NVEC] = '{
      {7'h41, 2'd1, 2'b0, 4'd0},
      {7'h61, 2'd1, 2'b0, 4'd0},
      {7'h20, 2'd1, 2'b0, 4'd0},
      {7'h3F, 2'd1, 2'b0, 4'd0},
      {7'h7F, 2'd1, 2'b0, 4'd0},
      {7'h00, 2'd0, 2'b0, 4'd0},
      {7'h1F, 2'd0, 2'b0, 4'd0},
      {7'h0C, 2'd0, 2'b0, 4'd0},
      {7'h0E, 2'd0, 2'b0, 4'd0},
      {7'h0D, 2'd2, 2'b0, 4'd3},
      {7'h4D, 2'd1, 2'b0, 4'd0},
      {7'h2D, 2'd1, 2'b0, 4'd0},
      {7'h0D, 2'd2, 2'b0, 4'd0},
      {7'h5D, 2'd1, 2'b0, 4'd0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] host_data = '0;
   logic       host_strobe = 1'b0;
   logic       slot_exposed = 1'b0;
   logic       line_start = 1'b0;
   logic       busy, ack_pulse, mem_wr, clr_req, cur_adv;
   logic [6:0] wr_char;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   char_accept_ctrl #(.CODE_W(7), .ACK_CYCLES(ACK_N)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_data    (host_data),
      .host_strobe  (host_strobe),
      .slot_exposed (slot_exposed),
      .line_start   (line_start),
      .busy         (busy),
      .ack_pulse    (ack_pulse),
      .mem_wr       (mem_wr),
      .clr_req      (clr_req),
      .cur_adv      (cur_adv),
      .wr_char      (wr_char)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expose(input logic ls);
      slot_exposed = 1'b1;
      line_start   = ls;
      tick();
      slot_exposed = 1'b0;
      line_start   = 1'b0;
   endtask

   task automatic ack_phase(input string req);
      for (int i = 1; i < ACK_N; i++) begin
         tick();
         check({req, " ack held"}, {ack_pulse, busy}, 2'b11);
         check({req, " one-cycle write"}, mem_wr, 1'b0);
      end
      tick();
      check({req, " ack end, busy drop"}, {ack_pulse, busy}, 2'b00);
   endtask

   task automatic send(input logic [6:0] code);
      host_data   = code;
      host_strobe = 1'b1;
      tick();
      host_strobe = 1'b0;
      check("R2 busy after strobe", busy, 1'b1);
      check("R2 code captured", wr_char, code);
   endtask

   task automatic run_vec(input logic [6:0] code, input logic [1:0] kind,
                          input logic [3:0] extra, input bit first_ls);
      send(code);
      tick();
      tick();
      check("R4 no write before exposure", {mem_wr, cur_adv, ack_pulse}, 3'b000);
      if (kind == 2'd2) begin
         expose(first_ls);
         check("R6 first blank write", {mem_wr, clr_req, cur_adv}, 3'b111);
         for (int j = 0; j < int'(extra); j++) begin
            tick();
            check("R6 idle gap no write", mem_wr, 1'b0);
            expose(1'b0);
            check("R6 further blank write", {mem_wr, clr_req, cur_adv}, 3'b111);
         end
         tick();
         expose(1'b1);
         check("R6 line start stops fill", {mem_wr, clr_req, cur_adv}, 3'b000);
         check("R7 ack starts after line start", ack_pulse, 1'b1);
         ack_phase("R7");
      end else if (kind == 2'd1) begin
         expose(1'b0);
         check("R4 printable write", {mem_wr, clr_req, cur_adv}, 3'b101);
         check("R7 ack start", ack_pulse, 1'b1);
         ack_phase("R7");
      end else begin
         expose(1'b0);
         check("R5 control dropped", {mem_wr, clr_req, cur_adv}, 3'b000);
         check("R5 ack still issued", ack_pulse, 1'b1);
         ack_phase("R5");
      end
   endtask

   initial begin
      repeat (3) tick();
      check("R1 reset outputs", {busy, ack_pulse, mem_wr, clr_req, cur_adv}, 5'b0);
      rst_n = 1'b1;
      tick();
      check("R1 after release", {busy, ack_pulse, mem_wr, clr_req, cur_adv}, 5'b0);

      // R8: exposures while idle
      expose(1'b0);
      check("R8 idle exposure", {busy, ack_pulse, mem_wr, clr_req, cur_adv}, 5'b0);
      expose(1'b1);
      check("R8 idle line start", {busy, ack_pulse, mem_wr, clr_req, cur_adv}, 5'b0);

      for (int v = 0; v < NVEC; v++) begin
         run_vec(VECS[v][14:8], VECS[v][7:6], VECS[v][3:0], 1'b0);
         tick();
      end

      // R6: line_start on the first pass of a return is not the stop point
      run_vec(7'h0D, 2'd2, 4'd1, 1'b1);
      tick();

      // R3: strobe while busy is ignored
      send(7'h42);
      host_data   = 7'h0D;
      host_strobe = 1'b1;
      tick();
      host_strobe = 1'b0;
      check("R3 held code kept", wr_char, 7'h42);
      expose(1'b0);
      check("R3 held code written", {mem_wr, clr_req, cur_adv}, 3'b101);
      ack_phase("R3");
      tick();
      check("R3 no second handling", {busy, mem_wr}, 2'b00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule